// File: doc/BRIEF.md
# Four-Lane 7:1 Display Link Serializer

This block turns a 28-bit parallel pixel word into five serial bit streams for a flat-panel display link. Each rising edge of the pixel clock captures one word. The word holds 24 colour bits and 4 timing and control bits. The word is split into four 7-bit groups. Each group leaves on its own data lane, one bit per bit-clock cycle, so a whole word is sent within one pixel period. A fifth lane sends a fixed framing waveform that repeats every pixel period. A receiver uses this waveform to find slot 0.

The serial side runs on a bit clock at seven times the pixel rate and phase-aligned with it. An outside strobe, `slot_sync`, is high for one bit-clock cycle per pixel period and marks the edge where slot 0 starts. The strobe is placed in the middle of the pixel period, so the captured word is stable when it is read. An active-low power-down input forces every lane low and drops the lane enable. After power-down is released, the outputs stay disabled until a word captured after the release has been loaded.

Top module: `lvds_link_ser`

## Requirements
- R1: The word on `pix_word` is captured only at a rising edge of `pix_clk`. Values it takes between those edges never reach the lanes.
- R2: Word layout: red is bits 7:0, green is bits 15:8, blue is bits 23:16, horizontal sync is bit 24, vertical sync is bit 25, data enable is bit 26, and the spare control is bit 27. For example, a word with only horizontal sync set shows a 1 on lane 3 in slot 3 and 0 on every other lane.
- R3: Data lane k sends word bits 7k to 7k+6, least-significant first. Slot s is the bit-clock cycle s edges after the load edge, and in it `lane_data[k]` equals word bit 7k+s.
- R4: In slots 0 to 6 the clock lane sends 1,1,0,0,0,1,1 (slot 0 first), so it is high in the first loaded slot.
- R5: A word is loaded only at a bit-clock edge where `slot_sync` is high, `pd_n` is high and a word not yet sent has been captured. Each word is loaded at most once. `lane_oe` rises only at such an edge.
- R6: At the first bit-clock edge where `pd_n` is low, `lane_oe`, all of `lane_data` and `lane_clk` go to 0, and they stay 0 while `pd_n` is low.
- R7: After `pd_n` returns high, `lane_oe` stays 0 until a word captured after the release is loaded. A word captured before power-down is never sent.
- R8: If `pd_n` is low at an edge where `slot_sync` is high, power-down wins: no load happens and `lane_oe` is 0 after that edge.
- R9: While `rst_n` is low (synchronous, active low, in both clock domains), `lane_oe`, `lane_data` and `lane_clk` are 0 after the next bit-clock edge.
- R10: A word captured at pixel edge N is recovered in full from the lanes before pixel edge N+2. That is a latency of one pixel period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; its rising edge captures the word |
| bit_clk | input | 1 | Bit clock at 7x the pixel rate, phase-aligned |
| rst_n | input | 1 | Synchronous active-low reset for both clock domains |
| pd_n | input | 1 | Active-low power-down |
| slot_sync | input | 1 | One bit-clock cycle per pixel period; marks the slot 0 load edge |
| pix_word | input | 28 | Parallel pixel word: colour, syncs, data enable, spare |
| lane_data | output | 4 | Serial data lanes, one bit per bit-clock cycle |
| lane_clk | output | 1 | Framing clock lane |
| lane_oe | output | 1 | Lane driver enable, high while serializing |

## Verification
Two functions can fall in the same bit-clock cycle: the slot 0 load and power-down. The bench drops `pd_n` in exactly the cycle where `slot_sync` is high. It then expects `lane_oe` low and all lanes zero after that edge, with no word sent. A second case pulses power-down for two cycles between pixel edges. This checks that the word already captured is not loaded again after release. On every bit clock, a behavioural model is compared against all outputs. A deserializer that frames on the clock-lane pattern then rebuilds each word and checks it against the words driven, together with its latency.

// File: rtl/lvds_ser_pkg.sv
// Package: shared field positions and the framing-clock waveform.
// Assumes at most 32 slots per pixel period.
package lvds_ser_pkg;

    // Field positions in the 28-bit pixel word
    localparam int FLD_RED_LSB   = 0;
    localparam int FLD_GREEN_LSB = 8;
    localparam int FLD_BLUE_LSB  = 16;
    localparam int FLD_HSYNC     = 24;
    localparam int FLD_VSYNC     = 25;
    localparam int FLD_DE        = 26;
    localparam int FLD_SPARE     = 27;

    // Framing waveform, slot 0 in bit 0.
    // High for the first and last slots/3 slots, low in the middle.
    function automatic logic [31:0] clk_pattern(input int slots);
        logic [31:0] pat;
        int          edge_w;
        pat    = '0;
        edge_w = slots / 3;
        for (int s = 0; s < slots; s++) begin
            pat[s] = (s < edge_w) || (s >= slots - edge_w);
        end
        return pat;
    endfunction

endpackage

// File: rtl/lvds_pix_capture.sv
// Pixel-domain capture register.
// Registers the parallel word on every rising pixel-clock edge while
// power-down is released, and toggles a flag for each capture.
// Assumes the bit domain reads the word only mid-period, when it is stable.
module lvds_pix_capture #(
    parameter int WORD_W = 28
) (
    input  logic              pix_clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic [WORD_W-1:0] pix_word,
    output logic [WORD_W-1:0] cap_word,
    output logic              cap_tog
);

    // Capture the word and flip the capture flag on each accepted edge
    always_ff @(posedge pix_clk) begin
        if (!rst_n) begin
            cap_word <= '0;
            cap_tog  <= 1'b0;
        end else if (pd_n) begin
            cap_word <= pix_word;
            cap_tog  <= ~cap_tog;
        end
    end

endmodule

// File: rtl/lvds_load_ctrl.sv
// Bit-domain load controller.
// Produces the slot 0 load strobe, the clear for power-down and the
// lane enable. A word is fresh when the capture flag differs from the
// value noted at the last load or power-down, so no word is sent twice.
// Assumes cap_tog is stable at every edge where slot_sync is high.
module lvds_load_ctrl (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic slot_sync,
    input  logic cap_tog,
    output logic load,
    output logic clear,
    output logic lane_en
);

    logic seen_tog;
    logic fresh;

    assign fresh = cap_tog != seen_tog;
    assign load  = pd_n && slot_sync && fresh;
    assign clear = !pd_n;

    // Note which capture was consumed (by a load) or discarded (by power-down)
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            seen_tog <= 1'b0;
        end else if (!pd_n || load) begin
            seen_tog <= cap_tog;
        end
    end

    // Lane enable: dropped by power-down, raised by the first load
    always_ff @(posedge bit_clk) begin
        if (!rst_n || !pd_n) begin
            lane_en <= 1'b0;
        end else if (load) begin
            lane_en <= 1'b1;
        end
    end

endmodule

// File: rtl/lvds_lane_shift.sv
// One serial lane: a parallel-load, right-shift register.
// Bit 0 of the loaded value is sent first. Zeros shift in after the last slot.
module lvds_lane_shift #(
    parameter int SLOTS = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [SLOTS-1:0] load_val,
    output logic             ser_o
);

    logic [SLOTS-1:0] sr;

    // Load at slot 0, otherwise shift one slot toward the output
    always_ff @(posedge bit_clk) begin
        if (!rst_n || clear) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else begin
            sr <= {1'b0, sr[SLOTS-1:1]};
        end
    end

    assign ser_o = sr[0];

endmodule

// File: rtl/lvds_link_ser.sv
// Top: four-lane 7:1 display link serializer with a framing clock lane.
// The pixel-domain capture feeds LANES data shifters and one clock-lane
// shifter. All of them load together at the slot 0 strobe.
// Assumes bit_clk is SLOTS x pix_clk, phase-aligned, and that slot_sync
// falls mid-period so the captured word is stable when loaded.
module lvds_link_ser #(
    parameter int LANES = 4,
    parameter int SLOTS = 7
) (
    input  logic                   pix_clk,
    input  logic                   bit_clk,
    input  logic                   rst_n,
    input  logic                   pd_n,
    input  logic                   slot_sync,
    input  logic [LANES*SLOTS-1:0] pix_word,
    output logic [LANES-1:0]       lane_data,
    output logic                   lane_clk,
    output logic                   lane_oe
);

    localparam int WORD_W = LANES * SLOTS;
    localparam logic [31:0] PAT_FULL = lvds_ser_pkg::clk_pattern(SLOTS);
    localparam logic [SLOTS-1:0] CLK_PAT = PAT_FULL[SLOTS-1:0];

    logic [WORD_W-1:0] cap_word;
    logic              cap_tog;
    logic              load;
    logic              clear;

    lvds_pix_capture #(.WORD_W(WORD_W)) u_cap (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .pix_word (pix_word),
        .cap_word (cap_word),
        .cap_tog  (cap_tog)
    );

    lvds_load_ctrl u_ctrl (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .slot_sync (slot_sync),
        .cap_tog   (cap_tog),
        .load      (load),
        .clear     (clear),
        .lane_en   (lane_oe)
    );

    // One shifter per data lane, lane k takes word bits k*SLOTS upward
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lvds_lane_shift #(.SLOTS(SLOTS)) u_sh (
            .bit_clk  (bit_clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .load     (load),
            .load_val (cap_word[k*SLOTS +: SLOTS]),
            .ser_o    (lane_data[k])
        );
    end

    // Framing lane, reloaded with the fixed pattern on every word
    lvds_lane_shift #(.SLOTS(SLOTS)) u_clk_lane (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load     (load),
        .load_val (CLK_PAT),
        .ser_o    (lane_clk)
    );

endmodule

// File: rtl/lvds_link_ser_chk.sv
// Checker for lvds_link_ser, attached with bind. Observes ports only.
module lvds_link_ser_chk #(
    parameter int LANES = 4
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             pd_n,
    input logic             slot_sync,
    input logic [LANES-1:0] lane_data,
    input logic             lane_clk,
    input logic             lane_oe
);

    // R9: reset silences every output
    a_r9_reset_quiet: assert property (@(posedge bit_clk)
        !rst_n |=> (!lane_oe && lane_data == '0 && !lane_clk));

    // R6: power-down disables and zeroes the lanes
    a_r6_pd_disables: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pd_n |=> (!lane_oe && lane_data == '0 && !lane_clk));

    // R8: power-down beats a coincident load strobe
    a_r8_pd_beats_load: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!pd_n && slot_sync) |=> !lane_oe);

    // R5: the enable rises only at a strobed load edge
    a_r5_enable_at_sync: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(lane_oe) |-> $past(slot_sync));

    // R4: the first loaded slot on the clock lane is high
    a_r4_slot0_high: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(lane_oe) |-> lane_clk);

endmodule

bind lvds_link_ser lvds_link_ser_chk #(.LANES(LANES)) u_chk (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .slot_sync (slot_sync),
    .lane_data (lane_data),
    .lane_clk  (lane_clk),
    .lane_oe   (lane_oe)
);

// File: tb/tb_lvds_link_ser.sv
// Bench: behavioural slot model compared every bit clock, plus a
// deserializer that frames on the clock-lane pattern.
module tb_lvds_link_ser;

    logic        bit_clk = 1'b0;
    logic        pix_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        slot_sync = 1'b0;
    logic [27:0] pix_word = '0;
    wire  [3:0]  lane_data;
    wire         lane_clk;
    wire         lane_oe;

    int checks = 0;
    int fails = 0;
    int pe = 0;
    int pix_cnt = 0;
    int mode = 0;
    int drv_mode = 0;
    int mode_age = 0;
    int seq = 0;
    bit running = 1'b0;
    string oe_req = "R5";

    localparam logic [6:0] CLKPAT = 7'b1100011;

    lvds_link_ser dut (
        .pix_clk (pix_clk), .bit_clk (bit_clk), .rst_n (rst_n), .pd_n (pd_n),
        .slot_sync (slot_sync), .pix_word (pix_word),
        .lane_data (lane_data), .lane_clk (lane_clk), .lane_oe (lane_oe)
    );

    // 125 MHz bit clock, pixel clock at one seventh, rising together
    always #4 bit_clk = ~bit_clk;
    initial begin
        #4;
        forever begin
            pix_clk = 1'b1; #28;
            pix_clk = 1'b0; #28;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Posedge index; strobe marks slot 0 at index 3 of each pixel period
    always @(posedge bit_clk) pe <= pe + 1;
    always @(negedge bit_clk) slot_sync <= (pe % 7 == 3);

    // Pixel driver: junk right after the fall, final word before the rise (R1)
    function automatic logic [27:0] next_word(input int m, input int s);
        case (m)
            0: return 28'(s * 32'h0123457);
            1: return s[0] ? 28'h5555555 : 28'hAAAAAAA;
            2: return 28'($urandom);
            3: return 28'(1) << (s % 28);
            default: return 28'(1) << 24;
        endcase
    endfunction

    always @(negedge pix_clk) begin
        pix_word = ~pix_word ^ 28'h3C3C3C3;
        #18;
        if (mode == drv_mode) mode_age++;
        else begin drv_mode = mode; mode_age = 0; end
        pix_word = next_word(mode, seq);
        seq++;
    end

    // Reference model
    logic [27:0] m_cap = '0;
    logic [27:0] m_frame = '0;
    bit          m_fresh = 1'b0;
    bit          m_oe = 1'b0;
    int          m_slot = 7;
    logic [27:0] wq[$];
    int          tq[$];

    always @(posedge pix_clk) begin
        pix_cnt++;
        if (rst_n && pd_n) begin
            m_cap   <= pix_word;
            m_fresh <= 1'b1;
            wq.push_back(pix_word);
            tq.push_back(pix_cnt);
        end
    end

    always @(posedge bit_clk) begin
        if (!rst_n || !pd_n) begin
            m_oe   <= 1'b0;
            m_slot <= 7;
            if (!pd_n) begin
                m_fresh <= 1'b0;
                wq.delete();
                tq.delete();
            end
        end else if (slot_sync && m_fresh) begin
            m_frame <= m_cap;
            m_fresh <= 1'b0;
            m_oe    <= 1'b1;
            m_slot  <= 0;
        end else if (m_slot < 7) begin
            m_slot <= m_slot + 1;
        end
    end

    // Per-cycle compare and deserializer
    int          run = 0;
    int          ds_slot = -1;
    bit          prev_oe = 1'b0;
    logic [27:0] ds_word = '0;

    always @(negedge bit_clk) begin
        if (running) begin
            logic [3:0] exp_d;
            logic       exp_c;
            for (int k = 0; k < 4; k++)
                exp_d[k] = (m_oe && m_slot < 7) ? m_frame[7*k + m_slot] : 1'b0;
            exp_c = (m_oe && m_slot < 7) ? CLKPAT[m_slot] : 1'b0;
            chk(lane_oe === m_oe, oe_req, 32'(lane_oe), 32'(m_oe));
            chk(lane_data === exp_d, "R3", 32'(lane_data), 32'(exp_d));
            chk(lane_clk === exp_c, "R4", 32'(lane_clk), 32'(exp_c));

            if (!lane_oe) begin
                run = 0;
                ds_slot = -1;
            end else begin
                run = lane_clk ? run + 1 : 0;
                if (!prev_oe || run == 3) ds_slot = 0;
                else if (ds_slot >= 0) ds_slot++;
                if (ds_slot >= 0 && ds_slot < 7) begin
                    for (int k = 0; k < 4; k++) ds_word[7*k + ds_slot] = lane_data[k];
                    if (mode == 4 && drv_mode == 4 && mode_age >= 3 && ds_slot == 3)
                        chk(lane_data == 4'b1000, "R2", 32'(lane_data), 32'h8);
                    if (ds_slot == 6) begin
                        if (wq.size() == 0) begin
                            chk(1'b0, "R1", 32'(ds_word), 32'hFFFFFFFF);
                        end else begin
                            chk(ds_word == wq[0], "R1", 32'(ds_word), 32'(wq[0]));
                            chk(pix_cnt - tq[0] == 1, "R10", 32'(pix_cnt - tq[0]), 32'd1);
                            void'(wq.pop_front());
                            void'(tq.pop_front());
                        end
                        ds_slot = -1;
                    end
                end
            end
            prev_oe = lane_oe;
        end
    end

    // Stimulus
    initial begin
        repeat (20) @(negedge bit_clk);
        chk(lane_oe == 1'b0, "R9", 32'(lane_oe), 32'd0);
        chk(lane_data == 4'h0, "R9", 32'(lane_data), 32'd0);
        chk(lane_clk == 1'b0, "R9", 32'(lane_clk), 32'd0);
        rst_n = 1'b1;
        running = 1'b1;
        oe_req = "R7";
        mode = 0; repeat (12) @(posedge pix_clk);
        oe_req = "R5";
        mode = 1; repeat (8)  @(posedge pix_clk);
        mode = 2; repeat (30) @(posedge pix_clk);
        mode = 3; repeat (30) @(posedge pix_clk);

        // Power-down held across several periods
        @(negedge bit_clk); pd_n = 1'b0;
        @(negedge bit_clk);
        chk(lane_oe == 1'b0, "R6", 32'(lane_oe), 32'd0);
        chk(lane_data == 4'h0, "R6", 32'(lane_data), 32'd0);
        chk(lane_clk == 1'b0, "R6", 32'(lane_clk), 32'd0);
        repeat (20) @(negedge bit_clk);
        oe_req = "R7";
        pd_n = 1'b1;
        @(negedge bit_clk);
        chk(lane_oe == 1'b0, "R7", 32'(lane_oe), 32'd0);
        repeat (6) @(posedge pix_clk);
        oe_req = "R5";

        // Short pulse between pixel edges: stale word must not be reloaded
        do @(negedge bit_clk); while (pe % 7 != 5);
        pd_n = 1'b0;
        @(negedge bit_clk); @(negedge bit_clk);
        oe_req = "R7";
        pd_n = 1'b1;
        repeat (4) @(posedge pix_clk);
        oe_req = "R5";

        // Power-down in the same cycle as the load strobe
        do @(negedge bit_clk); while (pe % 7 != 3);
        chk(lane_oe == 1'b1, "R8", 32'(lane_oe), 32'd1);
        pd_n = 1'b0;
        @(negedge bit_clk);
        chk(lane_oe == 1'b0, "R8", 32'(lane_oe), 32'd0);
        chk(lane_data == 4'h0, "R8", 32'(lane_data), 32'd0);
        repeat (3) @(negedge bit_clk);
        oe_req = "R7";
        pd_n = 1'b1;
        repeat (5) @(posedge pix_clk);
        oe_req = "R5";

        // Field layout: horizontal sync only
        mode = 4; repeat (10) @(posedge pix_clk);
        mode = 2; repeat (5)  @(posedge pix_clk);

        @(negedge bit_clk);
        running = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(50000 * 8);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule